// File: doc/BRIEF.md
# Cascadable Gated Interval Timer

This block is an interval timer made of two 16-bit count halves. Each half can run on its own with its own period, or the two can be joined into a single 32-bit counter. A two-bit field picks how many source ticks make one count step. The source tick is either the instruction-rate clock enable or an external tick that has already been synchronized. When the count reaches its period it returns to zero on the next step, and the block produces a one-cycle conversion-start pulse for an analog-to-digital converter.

An optional gated accumulation mode lets the count advance only while an external gate level is high. This is useful for measuring how long a signal stays high. When the gate falls, accumulation stops and the count is kept, so software can read it. Both period matches and gate falls set a sticky interrupt flag, which raises an interrupt request when software has enabled it. A sleep input stops all counting. Software reaches the block through a simple write port, selected by a 3-bit address, and reads the count from `count_out`.

Top module: `gtimer_cascade`

## Requirements
- R1: The prescale field (control bits 4:3) picks how many source ticks make one count step: 0 gives 1 tick, 1 gives 8, 2 gives 64 and 3 gives 256.
- R2: A half advances only when its run bit (control bit 0) is set. Its source is `tick_en`, or `ext_tick` when the external-source bit (control bit 1) is set.
- R3: When a count step happens while the count equals the period, the count becomes zero and `adc_trig` is high for exactly the following cycle. In 16-bit mode only the upper half's match does this.
- R4: Setting the join bit (bit 5 of the lower control register, address 4) makes one 32-bit counter {upper,lower} with the period {address 3, address 2}. In this mode the lower half's run, source, gate and prescale settings govern, and the upper control register's fields are ignored.
- R5: With the gate bit (control bit 2) set and the internal source selected, count steps happen only while `gate_in`, seen through one register stage, is high.
- R6: In that mode a falling edge of `gate_in`, including a low pulse of one cycle, stops accumulation, leaves the count unchanged and sets the interrupt flag.
- R7: The interrupt flag is set by a period match or a gate fall. It stays set until software writes 0 to bit 0 at address 6. If a set and a clear happen in the same cycle, the set wins.
- R8: `irq_req` is high exactly when the interrupt flag and the enable bit (bit 1 at address 6) are both set.
- R9: While a half is running, a write to either of its count registers clears its prescaler. So does a write to its control register that keeps the run bit set. In 32-bit mode, writes to the upper half's registers clear the lower prescaler.
- R10: A write to a control register that clears the run bit, a write made while the half is stopped, or a write that starts the half does not clear its prescaler.
- R11: While `sleep_in` is high the count does not change unless it is written.
- R12: Writing address 0 or 1 loads that count half. Writing a control register leaves the count unchanged. After reset, counts, flag, enable and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Instruction-rate tick |
| ext_tick | input | 1 | Synchronized external tick |
| gate_in | input | 1 | Accumulation gate level |
| sleep_in | input | 1 | Halts counting while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0/1 count lo/hi, 2/3 period lo/hi, 4/5 control lo/hi, 6 interrupt |
| wr_data | input | 16 | Write data |
| count_out | output | 32 | {upper count, lower count} |
| adc_trig | output | 1 | One-cycle conversion-start pulse |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_req | output | 1 | Flag gated by enable |

## Verification
The assertions assume that software never writes the interrupt register or a count register in the same cycle as the event it is probing. They also assume that `sleep_in` is only raised while no write is under way, and that reset is applied before the first check. The stimulus follows these rules: ticks are held low around every register write, gate and sleep change only at the falling clock edge, and prescalers are always brought to a known phase by a write that clears them before any ratio is measured.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
  typedef enum logic [2:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_PER_LO = 3'd2,
    A_PER_HI = 3'd3,
    A_CTL_LO = 3'd4,
    A_CTL_HI = 3'd5,
    A_IRQ    = 3'd6
  } gt_addr_e;

  typedef struct packed {
    logic       join32;
    logic [1:0] psc;
    logic       gate;
    logic       ext;
    logic       run;
  } gt_ctrl_t;
endpackage

// File: rtl/gtimer_prescaler.sv
module gtimer_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       adv,
  input  logic [1:0] sel,
  output logic       pulse
);
  logic [PSC_W-1:0] pcnt;
  logic [PSC_W-1:0] lim;

  always_comb begin
    case (sel)
      2'd0:    lim = PSC_W'(0);
      2'd1:    lim = PSC_W'(7);
      2'd2:    lim = PSC_W'(63);
      default: lim = PSC_W'(255);
    endcase
  end

  assign pulse = adv && !clr && (pcnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr) pcnt <= '0;
    else if (adv)   pcnt <= (pcnt >= lim) ? '0 : pcnt + 1'b1;
  end

  assert_div1_every_tick_R1: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && sel == 2'd0) |-> pulse);
endmodule

// File: rtl/gtimer_gate.sv
module gtimer_gate (
  input  logic clk,
  input  logic rst,
  input  logic gate_in,
  output logic level,
  output logic fall
);
  logic g2;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      g2    <= 1'b0;
    end else begin
      level <= gate_in;
      g2    <= level;
    end
  end

  assign fall = g2 && !level;
endmodule

// File: rtl/gtimer_cascade.sv
module gtimer_cascade
  import gtimer_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int PSC_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_en,
  input  logic                  ext_tick,
  input  logic                  gate_in,
  input  logic                  sleep_in,
  input  logic                  wr_en,
  input  logic [2:0]            wr_addr,
  input  logic [HALF_W-1:0]     wr_data,
  output logic [2*HALF_W-1:0]   count_out,
  output logic                  adc_trig,
  output logic                  irq_flag,
  output logic                  irq_req
);
  localparam int FULL_W = 2 * HALF_W;

  logic [HALF_W-1:0] cnt_q [2];
  logic [HALF_W-1:0] per_q [2];
  gt_ctrl_t          ctl_q [2];
  logic              irq_en;

  logic [1:0] adv, clr, pls, inc, wr_cnt, wr_ctl, wr_per;
  logic       gate_lvl, gate_fall, join32;

  assign join32 = ctl_q[0].join32;

  gtimer_gate u_gate (
    .clk(clk), .rst(rst), .gate_in(gate_in), .level(gate_lvl), .fall(gate_fall)
  );

  assign wr_cnt[0] = wr_en && wr_addr == A_CNT_LO;
  assign wr_cnt[1] = wr_en && wr_addr == A_CNT_HI;
  assign wr_per[0] = wr_en && wr_addr == A_PER_LO;
  assign wr_per[1] = wr_en && wr_addr == A_PER_HI;
  assign wr_ctl[0] = wr_en && wr_addr == A_CTL_LO;
  assign wr_ctl[1] = wr_en && wr_addr == A_CTL_HI;

  assign clr[0] = ctl_q[0].run && (wr_cnt[0] || (wr_ctl[0] && wr_data[0]) ||
                  (join32 && (wr_cnt[1] || wr_ctl[1])));
  assign clr[1] = ctl_q[1].run && (wr_cnt[1] || (wr_ctl[1] && wr_data[0]));

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic src;
    logic gate_ok;
    assign src     = ctl_q[h].ext ? ext_tick : tick_en;
    assign adv[h]  = ctl_q[h].run && !sleep_in && src;
    assign gate_ok = !(ctl_q[h].gate && !ctl_q[h].ext) || gate_lvl;
    assign inc[h]  = pls[h] && gate_ok;

    gtimer_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk(clk), .rst(rst), .clr(clr[h]), .adv(adv[h]),
      .sel(ctl_q[h].psc), .pulse(pls[h])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        per_q[h] <= '0;
        ctl_q[h] <= '0;
      end else begin
        if (wr_per[h]) per_q[h] <= wr_data;
        if (wr_ctl[h]) ctl_q[h] <= gt_ctrl_t'({(h == 0) && wr_data[5], wr_data[4:0]});
      end
    end
  end

  logic [FULL_W-1:0] full_cnt, full_per;
  logic [HALF_W-1:0] n_cnt [2];
  logic              ev_match, ev_gate, n_flag, n_en;

  assign full_cnt = {cnt_q[1], cnt_q[0]};
  assign full_per = {per_q[1], per_q[0]};

  always_comb begin
    n_cnt[0] = cnt_q[0];
    n_cnt[1] = cnt_q[1];
    ev_match = 1'b0;
    if (join32) begin
      if (inc[0]) begin
        if (full_cnt == full_per) begin
          {n_cnt[1], n_cnt[0]} = '0;
          ev_match = 1'b1;
        end else begin
          {n_cnt[1], n_cnt[0]} = full_cnt + 1'b1;
        end
      end
    end else begin
      if (inc[0]) n_cnt[0] = (cnt_q[0] == per_q[0]) ? '0 : cnt_q[0] + 1'b1;
      if (inc[1]) begin
        ev_match = cnt_q[1] == per_q[1];
        n_cnt[1] = ev_match ? '0 : cnt_q[1] + 1'b1;
      end
    end
    if (wr_cnt[0]) n_cnt[0] = wr_data;
    if (wr_cnt[1]) n_cnt[1] = wr_data;
  end

  always_comb begin
    if (join32) ev_gate = gate_fall && ctl_q[0].run && ctl_q[0].gate && !ctl_q[0].ext;
    else        ev_gate = gate_fall && ctl_q[1].run && ctl_q[1].gate && !ctl_q[1].ext;
    n_flag = irq_flag;
    n_en   = irq_en;
    if (wr_en && wr_addr == A_IRQ) begin
      n_flag = wr_data[0];
      n_en   = wr_data[1];
    end
    if (ev_match || ev_gate) n_flag = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q[0] <= '0;
      cnt_q[1] <= '0;
      adc_trig <= 1'b0;
      irq_flag <= 1'b0;
      irq_en   <= 1'b0;
      irq_req  <= 1'b0;
    end else begin
      cnt_q[0] <= n_cnt[0];
      cnt_q[1] <= n_cnt[1];
      adc_trig <= ev_match;
      irq_flag <= n_flag;
      irq_en   <= n_en;
      irq_req  <= n_flag && n_en;
    end
  end

  assign count_out = full_cnt;

  assert_sleep_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (sleep_in && !wr_en) |=> $stable(count_out));
  assert_trig_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
    adc_trig |-> irq_flag);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !(wr_en && wr_addr == A_IRQ)) |=> irq_flag);
  assert_req_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> (irq_en && irq_flag));
endmodule

// File: tb/gtimer_cascade_bench.sv
module gtimer_cascade_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, ext_tick = 1'b0, gate_in = 1'b0, sleep_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [31:0] count_out;
  logic        adc_trig, irq_flag, irq_req;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gtimer_cascade u_gtimer_cascade (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ext_tick(ext_tick),
    .gate_in(gate_in), .sleep_in(sleep_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count_out(count_out), .adc_trig(adc_trig),
    .irq_flag(irq_flag), .irq_req(irq_req)
  );

  localparam int NV = 5;
  localparam int V_PSC [NV] = '{0, 1, 1, 2, 3};
  localparam int V_TCK [NV] = '{10, 24, 23, 130, 600};
  localparam int V_EXP [NV] = '{10, 3, 2, 2, 2};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R12 reset count", count_out, 32'h0);
    check("R3 reset trig", {31'b0, adc_trig}, 32'h0);
    check("R8 reset irq", {30'b0, irq_flag, irq_req}, 32'h0);

    // R1: prescale ratios in 32-bit mode, period at maximum
    wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF);
    for (int i = 0; i < NV; i++) begin
      wr(3'd4, 16'h21 | 16'(V_PSC[i] << 3));
      wr(3'd0, 16'h0); wr(3'd1, 16'h0);
      ticks(V_TCK[i]);
      check("R1 prescaled count", count_out, 32'(V_EXP[i]));
    end
    wr(3'd4, 16'h39);
    check("R12 control write keeps count", count_out, 32'd2);

    // R10: writes that must not clear the prescaler
    wr(3'd4, 16'h29); wr(3'd0, 16'h0); wr(3'd1, 16'h0);
    ticks(5);
    wr(3'd4, 16'h28);
    wr(3'd0, 16'h0);
    wr(3'd4, 16'h29);
    ticks(3);
    check("R10 prescaler kept phase", count_out, 32'd1);
    // R9: count write while running clears it
    ticks(5);
    wr(3'd0, 16'h0);
    ticks(3);
    check("R9 cleared by count write", count_out, 32'd0);
    ticks(5);
    check("R9 full ratio after clear", count_out, 32'd1);

    // R11: sleep
    wr(3'd4, 16'h21); wr(3'd0, 16'h0);
    sleep_in = 1'b1; ticks(6); sleep_in = 1'b0;
    check("R11 no count in sleep", count_out, 32'd0);
    ticks(2);
    check("R11 counts after sleep", count_out, 32'd2);

    // R2: external source
    wr(3'd4, 16'h23); wr(3'd0, 16'h0);
    tick_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      ext_tick = (i % 2 == 0);
      @(negedge clk);
    end
    tick_en = 1'b0; ext_tick = 1'b0;
    check("R2 external ticks", count_out, 32'd3);
    wr(3'd4, 16'h20);
    ticks(4);
    check("R2 stopped half holds", count_out, 32'd3);

    // R3 R7 R8: 16-bit upper half match
    wr(3'd4, 16'h0); wr(3'd0, 16'h1234);
    wr(3'd3, 16'd3); wr(3'd5, 16'h01); wr(3'd1, 16'h0); wr(3'd6, 16'h0);
    ticks(3);
    check("R3 before match", count_out, 32'h0003_1234);
    check("R3 no early trig", {31'b0, adc_trig}, 32'h0);
    ticks(1);
    check("R3 wrap at period", count_out, 32'h0000_1234);
    check("R3 trig pulse", {31'b0, adc_trig}, 32'h1);
    check("R7 flag on match", {31'b0, irq_flag}, 32'h1);
    check("R8 no req when disabled", {31'b0, irq_req}, 32'h0);
    @(negedge clk);
    check("R3 trig one cycle", {31'b0, adc_trig}, 32'h0);
    repeat (3) @(negedge clk);
    check("R7 flag sticky", {31'b0, irq_flag}, 32'h1);
    wr(3'd6, 16'h3);
    check("R8 req when enabled", {31'b0, irq_req}, 32'h1);
    wr(3'd6, 16'h2);
    check("R7 software clear", {30'b0, irq_flag, irq_req}, 32'h0);

    // R4: 32-bit carry, combined period, upper fields ignored
    wr(3'd5, 16'h1D);
    wr(3'd4, 16'h21); wr(3'd2, 16'd2); wr(3'd3, 16'd1);
    wr(3'd0, 16'hFFFE); wr(3'd1, 16'h0); wr(3'd6, 16'h0);
    ticks(2);
    check("R4 carry into upper", count_out, 32'h0001_0000);
    ticks(2);
    check("R4 reach period", count_out, 32'h0001_0002);
    check("R4 no flag before match", {31'b0, irq_flag}, 32'h0);
    ticks(1);
    check("R4 32-bit wrap", count_out, 32'h0);
    check("R4 32-bit trig", {30'b0, adc_trig, irq_flag}, 32'h3);

    // R5 R6: gated accumulation
    wr(3'd5, 16'h0); wr(3'd4, 16'h25);
    wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF);
    wr(3'd0, 16'h0); wr(3'd1, 16'h0); wr(3'd6, 16'h0);
    ticks(3);
    check("R5 gate low blocks", count_out, 32'd0);
    gate_in = 1'b1; repeat (2) @(negedge clk);
    ticks(5);
    check("R5 gate high counts", count_out, 32'd5);
    tick_en = 1'b1; gate_in = 1'b0;
    repeat (4) @(negedge clk);
    tick_en = 1'b0;
    check("R6 fall freezes count", count_out, 32'd6);
    check("R6 fall sets flag", {31'b0, irq_flag}, 32'h1);
    wr(3'd6, 16'h0);
    gate_in = 1'b1; repeat (2) @(negedge clk);
    gate_in = 1'b0; @(negedge clk);
    gate_in = 1'b1; repeat (2) @(negedge clk);
    check("R6 short low pulse", {31'b0, irq_flag}, 32'h1);
    gate_in = 1'b0;
    wr(3'd0, 16'h0);
    check("R12 software restart", count_out, 32'd0);

    finish_run();
  end
endmodule